// File: doc/BRIEF.md
# Multi-Error ECC Correction Sequencer

This block runs the correction pass for one 512-byte data chunk guarded by a code that can repair up to four bad bytes. It is started with the ten ECC bytes that were stored alongside the chunk. It splits those bytes into eight 10-bit symbols and feeds them, last symbol first, to an external syndrome engine. If the returned syndrome is zero, it stops. Otherwise it kicks an external error locator and watches that locator's status. When the locator reports error positions, the sequencer fetches each address/value pair, turns the address into a byte offset, and repairs the chunk by read-modify-write through a single-port buffer.

A stored ECC field made only of 0xFF bytes marks an erased chunk, and the block skips it without touching either engine. Right after it is started, the locator may still show an old "finished" code. The sequencer therefore ignores low status codes until a busy code appears or a programmable cycle budget runs out. The same budget also limits how long it will poll for a result.

Each pass ends with a one-cycle `done` pulse. The number of bytes actually repaired and a failure flag stay valid on the outputs until the next start.

Top module: `eccFixSeq`

## Requirements
- R1: When every byte of `eccBytes` equals 0xFF (byte j on bits [8j+7:8j]), the pass completes with `corrCount` 0 and `failed` 0, and it raises no `loadValid`, `synReq` or `calcStart`.
- R2: Otherwise the block asserts `loadValid` for eight consecutive cycles. Symbol k is `eccBytes[10k+9:10k]`, and the symbols are presented in the order 7, 6, …, 0.
- R3: After the loads, `synReq` stays high until `synValid`. Word w of `synWords` is bits [32w+31:32w], and only its fields [9:0] and [25:16] are examined. If all eight fields are zero, the pass ends with count 0 and no `calcStart`.
- R4: A nonzero syndrome produces exactly one single-cycle `calcStart`, followed by `statReq` status sampling.
- R5: During the settle phase after `calcStart`, statuses whose code (`statWord[11:8]`) is below 4 are ignored. The phase ends at the first valid status with a code of 4 or more, or when `waitLimit` cycles have elapsed.
- R6: While polling, a valid status code of 0 ends the pass with count 0. Code 1 ends it with `failed` set and count 0. Codes 2 and 3 start the fix-up of 1 + `statWord[17:16]` errors. Codes of 4 and above keep the block polling.
- R7: If polling sees no valid status below 4 within `waitLimit` cycles, the pass ends with `failed` set. A valid decodable status that arrives in the cycle the budget expires takes priority over the timeout.
- R8: Errors 0 and 1 are fetched with `pairSel`=0 and errors 2 and 3 with `pairSel`=1. Even errors use the lower halves and odd errors the upper halves (bits [25:16] for the address, [23:16] for the value). The address is 10 bits and the value is 8 bits.
- R9: The byte offset is 519 minus the raw address. Only an offset below 512 is repaired: the byte is read, and in the next cycle the same address is written with the read data XOR the value.
- R10: `corrCount` equals the number of repairs applied, `done` is a one-cycle pulse, and the results are held until the next accepted start. After reset `done`, `failed` and `corrCount` are 0.
- R11: A `start` that arrives while a pass is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a correction pass (accepted only when idle) |
| eccBytes | input | 80 | Ten stored ECC bytes, byte 0 in the lowest bits |
| waitLimit | input | 16 | Cycle budget for the settle and polling phases |
| loadValid | output | 1 | Symbol load strobe to the syndrome engine |
| loadData | output | 10 | Symbol being loaded |
| synReq | output | 1 | Request for the syndrome words |
| synValid | input | 1 | Syndrome words are valid |
| synWords | input | 128 | Four syndrome words |
| calcStart | output | 1 | One-cycle start pulse to the locator |
| statReq | output | 1 | Status sample request |
| statValid | input | 1 | Status word is valid |
| statWord | input | 32 | Locator status: code [11:8], count [17:16] |
| pairReq | output | 1 | Address/value pair request |
| pairSel | output | 1 | Which pair register (0: errors 0–1, 1: errors 2–3) |
| pairValid | input | 1 | Pair words are valid |
| pairAddrWord | input | 32 | Two packed error addresses |
| pairValWord | input | 32 | Two packed error values |
| bufEn | output | 1 | Data buffer access enable |
| bufWe | output | 1 | Data buffer write enable |
| bufAddr | output | 9 | Data buffer byte address |
| bufWdata | output | 8 | Data buffer write data |
| bufRdata | input | 8 | Data buffer read data, one cycle after a read |
| done | output | 1 | Pass complete (one cycle) |
| failed | output | 1 | Pass ended uncorrectable or timed out |
| corrCount | output | 3 | Number of bytes repaired |

## Verification
Two things can land in the same cycle while polling: the expiry of the cycle budget and the arrival of a valid status word. The bench provokes this by sending a single status answer on an exact sample count. That count is derived from `waitLimit`: the settle phase lasts limit+1 samples and so does polling. An answer on sample 2·limit+2 must be decoded into a repair. An answer one sample later must never be seen, and the pass must end failed. The settle phase is probed the same way, with stale code-3 statuses placed before and after the first busy code.

// File: rtl/eccfix_pkg.sv
package eccfix_pkg;
  // Field positions of the locator status word and packed pair words
  localparam int STAT_CODE_LSB = 8;
  localparam int STAT_CNT_LSB  = 16;
  localparam int HALF_LSB      = 16;
  localparam int CODE_W        = 4;
  localparam int CNT_W         = 3;
  localparam int VAL_W         = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_SYN, ST_CALC, ST_SETTLE,
    ST_POLL, ST_FETCH, ST_READ, ST_WRITE, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic captureEcc;
    logic clrResult;
    logic latchCount;
    logic latchPair;
    logic applyFix;
    logic setFail;
  } seqStrobe_t;
endpackage

// File: rtl/eccfix_dpath.sv
module eccfix_dpath
  import eccfix_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int SYM_W       = 10,
  parameter int NUM_SYM     = 8,
  parameter int SYN_WORDS   = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  seqStrobe_t                     strb,
  input  logic [$clog2(NUM_SYM)-1:0]     loadIdx,
  input  logic [1:0]                     errIdx,
  input  logic [SYM_W*NUM_SYM-1:0]       eccBytes,
  input  logic [32*SYN_WORDS-1:0]        synWords,
  input  logic [31:0]                    statWord,
  input  logic [31:0]                    pairAddrWord,
  input  logic [31:0]                    pairValWord,
  input  logic [VAL_W-1:0]               bufRdata,
  output logic                           erasedIn,
  output logic                           synZero,
  output logic [CODE_W-1:0]              statCode,
  output logic                           isLast,
  output logic                           offsetOk,
  output logic [SYM_W-1:0]               loadData,
  output logic [$clog2(CHUNK_BYTES)-1:0] bufAddr,
  output logic [VAL_W-1:0]               bufWdata,
  output logic [CNT_W-1:0]               corrCount,
  output logic                           failed
);
  localparam int ECC_BITS = SYM_W * NUM_SYM;
  localparam int ADDR_W   = $clog2(CHUNK_BYTES);
  localparam int BIAS     = CHUNK_BYTES + 7;
  localparam int DIFF_W   = ((SYM_W > ADDR_W + 1) ? SYM_W : ADDR_W + 1) + 1;

  logic [ECC_BITS-1:0] eccReg;
  logic [SYM_W-1:0]    symArr [NUM_SYM];
  logic [SYN_WORDS-1:0] wordZero;
  logic [CNT_W-1:0]    numErr;
  logic [SYM_W-1:0]    rawAddr;
  logic [VAL_W-1:0]    fixVal;
  logic [DIFF_W-1:0]   offDiff;
  logic [15:0]         addrHalf;
  logic [15:0]         valHalf;

  // Symbol split of the captured ECC field
  for (genvar k = 0; k < NUM_SYM; k++) begin : gSym
    assign symArr[k] = eccReg[k*SYM_W +: SYM_W];
  end
  assign loadData = symArr[loadIdx];
  assign erasedIn = &eccBytes;

  // Zero test of the two fields held in each syndrome word
  for (genvar w = 0; w < SYN_WORDS; w++) begin : gSyn
    assign wordZero[w] = ~|synWords[32*w +: SYM_W] &
                         ~|synWords[32*w + HALF_LSB +: SYM_W];
  end
  assign synZero  = &wordZero;
  assign statCode = statWord[STAT_CODE_LSB +: CODE_W];

  // Half selection of the packed pair words
  assign addrHalf = errIdx[0] ? pairAddrWord[HALF_LSB +: 16] : pairAddrWord[15:0];
  assign valHalf  = errIdx[0] ? pairValWord[HALF_LSB +: 16]  : pairValWord[15:0];

  assign offDiff  = DIFF_W'(BIAS) - DIFF_W'(rawAddr);
  assign offsetOk = offDiff < DIFF_W'(CHUNK_BYTES);
  assign bufAddr  = offDiff[ADDR_W-1:0];
  assign bufWdata = bufRdata ^ fixVal;
  assign isLast   = ({1'b0, errIdx} + CNT_W'(1)) == numErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eccReg    <= '0;
      numErr    <= '0;
      rawAddr   <= '0;
      fixVal    <= '0;
      corrCount <= '0;
      failed    <= 1'b0;
    end else begin
      if (strb.captureEcc) eccReg <= eccBytes;
      if (strb.latchCount)
        numErr <= CNT_W'(statWord[STAT_CNT_LSB +: 2]) + CNT_W'(1);
      if (strb.latchPair) begin
        rawAddr <= addrHalf[SYM_W-1:0];
        fixVal  <= valHalf[VAL_W-1:0];
      end
      if (strb.clrResult) begin
        corrCount <= '0;
        failed    <= 1'b0;
      end else begin
        if (strb.applyFix) corrCount <= corrCount + CNT_W'(1);
        if (strb.setFail)  failed    <= 1'b1;
      end
    end
  end

  logic unusedBits;
  assign unusedBits = ^{statWord[31:STAT_CNT_LSB+2], statWord[STAT_CNT_LSB-1:STAT_CODE_LSB+CODE_W],
                        statWord[STAT_CODE_LSB-1:0], addrHalf[15:SYM_W], valHalf[15:VAL_W]};
endmodule

// File: rtl/eccfix_ctrl.sv
module eccfix_ctrl
  import eccfix_pkg::*;
#(
  parameter int NUM_SYM = 8,
  parameter int WAIT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [WAIT_W-1:0]          waitLimit,
  input  logic                       erasedIn,
  input  logic                       synValid,
  input  logic                       synZero,
  input  logic                       statValid,
  input  logic [CODE_W-1:0]          statCode,
  input  logic                       pairValid,
  input  logic                       offsetOk,
  input  logic                       isLast,
  output seqStrobe_t                 strb,
  output logic [$clog2(NUM_SYM)-1:0] loadIdx,
  output logic [1:0]                 errIdx,
  output logic                       loadValid,
  output logic                       synReq,
  output logic                       calcStart,
  output logic                       statReq,
  output logic                       pairReq,
  output logic                       pairSel,
  output logic                       bufEn,
  output logic                       bufWe,
  output logic                       done
);
  localparam int LIDX_W = $clog2(NUM_SYM);

  seqState_t         state, nxt;
  logic [WAIT_W-1:0] waitCnt;
  logic              timedOut;
  logic              clrWait;
  logic              advErr;
  logic              busyCode;

  assign timedOut = waitCnt >= waitLimit;
  assign busyCode = statCode >= CODE_W'(4);

  always_comb begin
    nxt     = state;
    strb    = '0;
    clrWait = 1'b0;
    advErr  = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.captureEcc = 1'b1;
        strb.clrResult  = 1'b1;
        nxt = erasedIn ? ST_DONE : ST_LOAD;
      end
      ST_LOAD:   if (loadIdx == '0) nxt = ST_SYN;
      ST_SYN:    if (synValid) nxt = synZero ? ST_DONE : ST_CALC;
      ST_CALC: begin
        clrWait = 1'b1;
        nxt     = ST_SETTLE;
      end
      ST_SETTLE: if ((statValid && busyCode) || timedOut) begin
        clrWait = 1'b1;
        nxt     = ST_POLL;
      end
      ST_POLL: begin
        if (statValid && !busyCode) begin
          unique case (statCode)
            CODE_W'(0): nxt = ST_DONE;
            CODE_W'(1): begin
              strb.setFail = 1'b1;
              nxt = ST_DONE;
            end
            default: begin
              strb.latchCount = 1'b1;
              nxt = ST_FETCH;
            end
          endcase
        end else if (timedOut) begin
          strb.setFail = 1'b1;
          nxt = ST_DONE;
        end
      end
      ST_FETCH: if (pairValid) begin
        strb.latchPair = 1'b1;
        nxt = ST_READ;
      end
      ST_READ: begin
        if (offsetOk)    nxt = ST_WRITE;
        else if (isLast) nxt = ST_DONE;
        else begin
          advErr = 1'b1;
          nxt    = ST_FETCH;
        end
      end
      ST_WRITE: begin
        strb.applyFix = 1'b1;
        if (isLast) nxt = ST_DONE;
        else begin
          advErr = 1'b1;
          nxt    = ST_FETCH;
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      loadIdx <= LIDX_W'(NUM_SYM - 1);
      errIdx  <= '0;
      waitCnt <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE)      loadIdx <= LIDX_W'(NUM_SYM - 1);
      else if (state == ST_LOAD) loadIdx <= loadIdx - LIDX_W'(1);
      if (strb.latchCount) errIdx <= '0;
      else if (advErr)     errIdx <= errIdx + 2'd1;
      if (clrWait) waitCnt <= '0;
      else if ((state == ST_SETTLE || state == ST_POLL) && !timedOut)
        waitCnt <= waitCnt + WAIT_W'(1);
    end
  end

  assign loadValid = state == ST_LOAD;
  assign synReq    = state == ST_SYN;
  assign calcStart = state == ST_CALC;
  assign statReq   = (state == ST_SETTLE) || (state == ST_POLL);
  assign pairReq   = state == ST_FETCH;
  assign pairSel   = errIdx[1];
  assign bufEn     = (state == ST_READ && offsetOk) || (state == ST_WRITE);
  assign bufWe     = state == ST_WRITE;
  assign done      = state == ST_DONE;
endmodule

// File: rtl/eccFixSeq.sv
module eccFixSeq
  import eccfix_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int SYM_W       = 10,
  parameter int NUM_SYM     = 8,
  parameter int SYN_WORDS   = 4,
  parameter int WAIT_W      = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [SYM_W*NUM_SYM-1:0]       eccBytes,
  input  logic [WAIT_W-1:0]              waitLimit,
  output logic                           loadValid,
  output logic [SYM_W-1:0]               loadData,
  output logic                           synReq,
  input  logic                           synValid,
  input  logic [32*SYN_WORDS-1:0]        synWords,
  output logic                           calcStart,
  output logic                           statReq,
  input  logic                           statValid,
  input  logic [31:0]                    statWord,
  output logic                           pairReq,
  output logic                           pairSel,
  input  logic                           pairValid,
  input  logic [31:0]                    pairAddrWord,
  input  logic [31:0]                    pairValWord,
  output logic                           bufEn,
  output logic                           bufWe,
  output logic [$clog2(CHUNK_BYTES)-1:0] bufAddr,
  output logic [VAL_W-1:0]               bufWdata,
  input  logic [VAL_W-1:0]               bufRdata,
  output logic                           done,
  output logic                           failed,
  output logic [CNT_W-1:0]               corrCount
);
  localparam int LIDX_W = $clog2(NUM_SYM);

  seqStrobe_t        strb;
  logic [LIDX_W-1:0] loadIdx;
  logic [1:0]        errIdx;
  logic              erasedIn, synZero, isLast, offsetOk;
  logic [CODE_W-1:0] statCode;

  eccfix_ctrl #(.NUM_SYM(NUM_SYM), .WAIT_W(WAIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .waitLimit(waitLimit),
    .erasedIn(erasedIn), .synValid(synValid), .synZero(synZero),
    .statValid(statValid), .statCode(statCode), .pairValid(pairValid),
    .offsetOk(offsetOk), .isLast(isLast), .strb(strb), .loadIdx(loadIdx),
    .errIdx(errIdx), .loadValid(loadValid), .synReq(synReq),
    .calcStart(calcStart), .statReq(statReq), .pairReq(pairReq),
    .pairSel(pairSel), .bufEn(bufEn), .bufWe(bufWe), .done(done)
  );

  eccfix_dpath #(.CHUNK_BYTES(CHUNK_BYTES), .SYM_W(SYM_W), .NUM_SYM(NUM_SYM),
                 .SYN_WORDS(SYN_WORDS)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .loadIdx(loadIdx), .errIdx(errIdx),
    .eccBytes(eccBytes), .synWords(synWords), .statWord(statWord),
    .pairAddrWord(pairAddrWord), .pairValWord(pairValWord), .bufRdata(bufRdata),
    .erasedIn(erasedIn), .synZero(synZero), .statCode(statCode), .isLast(isLast),
    .offsetOk(offsetOk), .loadData(loadData), .bufAddr(bufAddr),
    .bufWdata(bufWdata), .corrCount(corrCount), .failed(failed)
  );
endmodule

// File: rtl/eccfix_chk.sv
module eccfix_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadValid,
  input logic              synReq,
  input logic              calcStart,
  input logic              bufEn,
  input logic              bufWe,
  input logic [ADDR_W-1:0] bufAddr,
  input logic              done,
  input logic              failed,
  input logic [2:0]        corrCount
);
  assert_load_then_syn_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loadValid) |-> synReq);

  assert_calc_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    calcStart |=> !calcStart);

  assert_fail_no_fix_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && failed) |-> corrCount == 3'd0);

  assert_write_enabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> bufEn);

  assert_write_after_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> ($past(bufEn && !bufWe) && bufAddr == $past(bufAddr)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> corrCount <= 3'd4);
endmodule

bind eccFixSeq eccfix_chk #(.ADDR_W($clog2(CHUNK_BYTES))) uChk (
  .clk(clk), .rstN(rstN), .loadValid(loadValid), .synReq(synReq),
  .calcStart(calcStart), .bufEn(bufEn), .bufWe(bufWe), .bufAddr(bufAddr),
  .done(done), .failed(failed), .corrCount(corrCount)
);

// File: tb/tb_eccFixSeq.sv
module tb_eccFixSeq;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [79:0]  eccBytes = '0;
  logic [15:0]  waitLimit = 16'd20;
  logic         loadValid, synReq, calcStart, statReq, pairReq, pairSel;
  logic [9:0]   loadData;
  logic         synValid = 1'b0, statValid = 1'b0, pairValid = 1'b0;
  logic [127:0] synWords = '0;
  logic [31:0]  statWord = '0, pairAddrWord = '0, pairValWord = '0;
  logic         bufEn, bufWe, done, failed;
  logic [8:0]   bufAddr;
  logic [7:0]   bufWdata;
  logic [7:0]   bufRdata = '0;
  logic [2:0]   corrCount;

  eccFixSeq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  // engine model configuration
  logic [127:0] cfgSyn;
  int cfgStale = 0, cfgBusy = 0, cfgShot = 0;
  logic [31:0] cfgFinal;
  logic [31:0] cfgAddr [2];
  logic [31:0] cfgVal [2];
  int reqCount = 0, loadN = 0, calcSeen = 0, synSeen = 0;
  logic [9:0] loadLog [16];
  logic [7:0] mem [512];
  logic [7:0] expMem [512];
  int expCnt;

  function automatic logic [31:0] mkStat(int code, int cnt);
    return (32'(cnt & 3) << 16) | (32'(code & 15) << 8) | 32'h1;
  endfunction

  always @(negedge clk) begin
    if (loadValid) begin
      if (loadN < 16) loadLog[loadN] = loadData;
      loadN++;
    end
    if (synReq) synSeen++;
    synValid = synReq;
    synWords = cfgSyn;
    if (calcStart) begin
      calcSeen++;
      reqCount = 0;
    end
    if (statReq) begin
      reqCount++;
      if (cfgShot > 0) begin
        statValid = (reqCount == cfgShot);
        statWord  = cfgFinal;
      end else begin
        statValid = 1'b1;
        if (reqCount <= cfgStale)                statWord = mkStat(3, 0);
        else if (reqCount <= cfgStale + cfgBusy) statWord = mkStat(4 + (reqCount & 7), 2);
        else                                     statWord = cfgFinal;
      end
    end else statValid = 1'b0;
    pairValid    = pairReq;
    pairAddrWord = cfgAddr[pairSel];
    pairValWord  = cfgVal[pairSel];
  end

  always @(posedge clk) begin
    if (bufEn) begin
      if (bufWe) mem[bufAddr] <= bufWdata;
      else       bufRdata <= mem[bufAddr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Configure n errors; the locator answers with code (2 or 3)
  task automatic setErr(input int n, input int raw[4], input int val[4], input int code);
    for (int p = 0; p < 2; p++) begin
      cfgAddr[p] = {$urandom_range(63,0) > 0 ? 6'h2a : 6'h15, raw[2*p+1][9:0],
                    6'h3f, raw[2*p][9:0]};
      cfgVal[p]  = {8'hc3, val[2*p+1][7:0], 8'h5a, val[2*p][7:0]};
    end
    cfgFinal = mkStat(code, n - 1);
    for (int i = 0; i < 512; i++) expMem[i] = mem[i];
    expCnt = 0;
    for (int i = 0; i < n; i++) begin
      int off = 519 - raw[i];
      if (off >= 0 && off < 512) begin
        expMem[off] = expMem[off] ^ val[i][7:0];
        expCnt++;
      end
    end
  endtask

  task automatic runJob(input logic [79:0] ecc, input int limit);
    eccBytes  = ecc;
    waitLimit = 16'(limit);
    loadN = 0; calcSeen = 0; synSeen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 3000 && !done; c++) @(negedge clk);
  endtask

  task automatic checkEnd(input string req, input int eCnt, input bit eFail);
    int bad = 0;
    chk(done === 1'b1, req, "pass finished", int'(done), 1);
    chk(corrCount == 3'(eCnt), req, "corrCount", int'(corrCount), eCnt);
    chk(failed == eFail, req, "failed flag", int'(failed), int'(eFail));
    for (int i = 0; i < 512; i++) if (mem[i] !== expMem[i]) bad++;
    chk(bad == 0, req, "buffer mismatches", bad, 0);
  endtask

  task automatic checkLoads(input logic [79:0] ecc, input string req);
    int bad = 0;
    for (int k = 0; k < 8; k++) if (loadLog[k] !== ecc[(7-k)*10 +: 10]) bad++;
    chk(loadN == 8, req, "load count", loadN, 8);
    chk(bad == 0, req, "symbol order mismatches", bad, 0);
  endtask

  task automatic noErrExp();
    for (int i = 0; i < 512; i++) expMem[i] = mem[i];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int raw[4];
    int val[4];
    logic [79:0] ecc;
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    cfgSyn = '0; cfgSyn[3] = 1'b1;
    cfgFinal = mkStat(0, 0);
    cfgAddr[0] = '0; cfgAddr[1] = '0; cfgVal[0] = '0; cfgVal[1] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(done == 1'b0 && failed == 1'b0 && corrCount == 3'd0, "R10", "reset outputs",
        int'({done, failed, corrCount}), 0);
    chk(loadValid == 1'b0 && bufEn == 1'b0, "R10", "reset strobes", int'({loadValid, bufEn}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: erased chunk bypass
    noErrExp();
    runJob({80{1'b1}}, 20);
    checkEnd("R1", 0, 1'b0);
    chk(loadN == 0 && synSeen == 0 && calcSeen == 0, "R1", "engine activity",
        loadN + synSeen + calcSeen, 0);
    @(negedge clk);

    // R1/R2: one byte not 0xFF is not erased
    ecc = {{72{1'b1}}, 8'hfe};
    cfgSyn = '0;
    noErrExp();
    runJob(ecc, 20);
    checkLoads(ecc, "R2");
    chk(calcSeen == 0, "R1", "no locator after zero syndrome", calcSeen, 0);
    @(negedge clk);

    // R3: masked syndrome bits ignored
    cfgSyn = {4{32'hfc00_fc00}};
    ecc = 80'h1234_5678_9abc_def0_1357;
    runJob(ecc, 20);
    checkEnd("R3", 0, 1'b0);
    chk(calcSeen == 0, "R3", "calcStart count with zero fields", calcSeen, 0);
    @(negedge clk);

    // R3/R4: top field bit of last word triggers locator; code 0 ends clean (R6)
    cfgSyn = '0; cfgSyn[96+25] = 1'b1;
    cfgStale = 0; cfgBusy = 2; cfgShot = 0; cfgFinal = mkStat(0, 3);
    runJob(ecc, 20);
    chk(calcSeen == 1, "R4", "calcStart pulses", calcSeen, 1);
    checkEnd("R6", 0, 1'b0);
    @(negedge clk);

    // R6: code 1 means uncorrectable
    cfgFinal = mkStat(1, 3);
    runJob(ecc, 20);
    checkEnd("R6", 0, 1'b1);
    @(negedge clk);

    // R9: offset boundaries 511, 0, 512 (skip), beyond range (skip)
    raw = '{8, 519, 7, 520}; val = '{8'h81, 8'h42, 8'h24, 8'h18};
    cfgStale = 0; cfgBusy = 1;
    setErr(4, raw, val, 2);
    runJob(ecc, 20);
    checkEnd("R9", expCnt, 1'b0);
    chk(expCnt == 2, "R9", "bench boundary count", expCnt, 2);
    @(negedge clk);

    // R5: stale code 3 before the busy code is ignored (count from final status)
    raw = '{100, 200, 300, 400}; val = '{1, 2, 4, 8};
    cfgStale = 2; cfgBusy = 2;
    setErr(4, raw, val, 3);
    runJob(ecc, 20);
    checkEnd("R5", 4, 1'b0);
    @(negedge clk);

    // R5: stale code persists past the settle budget, then is decoded (1 error)
    cfgStale = 1000; cfgBusy = 0;
    setErr(1, raw, val, 2);
    runJob(ecc, 4);
    checkEnd("R5", 1, 1'b0);
    @(negedge clk);

    // R7: valid status in the exact cycle the poll budget expires wins
    cfgStale = 0; cfgShot = 2 * 5 + 2;
    setErr(2, raw, val, 2);
    runJob(ecc, 5);
    checkEnd("R7", 2, 1'b0);
    @(negedge clk);

    // R7: one sample too late -> timeout failure
    cfgShot = 2 * 5 + 3;
    noErrExp();
    runJob(ecc, 5);
    checkEnd("R7", 0, 1'b1);
    cfgShot = 0;
    @(negedge clk);

    // R11: start during a pass is ignored
    raw = '{50, 60, 70, 80}; val = '{8'h10, 8'h20, 8'h30, 8'h40};
    cfgStale = 1; cfgBusy = 1;
    setErr(3, raw, val, 2);
    ecc = 80'h0f0f_1e1e_2d2d_3c3c_4b4b;
    eccBytes = ecc; waitLimit = 16'd20; loadN = 0; calcSeen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    eccBytes = {80{1'b1}}; start = 1'b1;
    @(negedge clk); start = 1'b0; eccBytes = ecc;
    for (int c = 0; c < 3000 && !done; c++) @(negedge clk);
    checkLoads(ecc, "R11");
    checkEnd("R11", 3, 1'b0);
    chk(calcSeen == 1, "R11", "single locator start", calcSeen, 1);
    @(negedge clk);

    // R8/R9/R10/R2: random passes
    for (int t = 0; t < 40; t++) begin
      int n = 1 + int'($urandom_range(3, 0));
      for (int i = 0; i < 4; i++) begin
        if ($urandom_range(3, 0) == 0)
          raw[i] = ($urandom_range(1, 0) == 0) ? int'($urandom_range(7, 0))
                                              : int'($urandom_range(1023, 520));
        else raw[i] = int'($urandom_range(519, 8));
        val[i] = int'($urandom_range(255, 1));
      end
      ecc = {$urandom, $urandom, $urandom};
      ecc[0] = 1'b0;
      cfgSyn = '0; cfgSyn[$urandom_range(3, 0)*32 + $urandom_range(9, 0)] = 1'b1;
      cfgStale = int'($urandom_range(2, 0)); cfgBusy = int'($urandom_range(3, 0));
      setErr(n, raw, val, 2 + int'($urandom_range(1, 0)));
      runJob(ecc, 30);
      checkLoads(ecc, "R2");
      checkEnd("R8", expCnt, 1'b0);
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule